// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is a register file in which every procedure addresses 32 logical registers. The physical storage is larger (136 entries) and is carved into eight windows that form a ring. A current-window input picks which window the 24 non-global logical registers refer to. Logical indices 0 to 7 are globals: they reach the same storage whichever window is active, and index 0 is hard-wired to zero.

Each window has three groups of eight: outgoing temporaries (logical 8 to 15), private locals (16 to 23) and incoming parameters (24 to 31). A window's temporaries are the same storage as the next window's parameters. A caller therefore leaves arguments in its temporaries, the window pointer advances, and the callee finds them as parameters without any copy. The last window's temporaries wrap around to window 0's parameters. Two combinational read ports and one clocked write port all use the same window pointer. A write is forwarded to a read of the same storage in the same cycle.

Top module: `windowed_regfile`

## Requirements
- R1: After reset, every logical register reads as zero in every window on both read ports.
- R2: Logical registers 1 to 7 reach the same storage for every window pointer value. A value written under one window reads back unchanged under all eight.
- R3: Logical register 0 always reads zero on both ports, and writes to it have no effect.
- R4: For logical index L from 8 to 31 and window w, the physical entry is 8 + ((104 + (L-8) - 16*w) mod 128). Window 0 places temporaries at 112..119, locals at 120..127 and parameters at 128..135.
- R5: A value written to temporary k (logical 8+k) in window w reads back as parameter k (logical 24+k) in window (w+1) mod 8. This includes the wrap from window 7 to window 0.
- R6: Locals (logical 16 to 23) are private to their window. Writing them changes no temporary or parameter of any window, and no local of another window.
- R7: The two read ports are independent and can read different logical registers in the same cycle.
- R8: When the write port and a read port address the same physical entry in the same cycle, the read port returns the write data in that cycle.
- R9: A write with the enable high takes effect at the rising clock edge and is held until that entry is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears all entries |
| cwp | input | 3 | Current window pointer |
| we | input | 1 | Write enable |
| wa_addr | input | 5 | Logical write index |
| wa_data | input | 32 | Write data |
| ra_addr | input | 5 | Logical index for read port A |
| ra_data | output | 32 | Read port A data (combinational) |
| rb_addr | input | 5 | Logical index for read port B |
| rb_data | output | 32 | Read port B data (combinational) |

## Verification
The two functions that can meet in one cycle are a write and a combinational read that resolve to the same physical entry. In that case the read must return the incoming data, not the stored value. The bench provokes this by holding a write and pointing read port A at the same logical index under the same window. Port B is pointed at an untouched register at the same time. Mid-cycle, before the edge, the bench checks that A already shows the new data and B shows the old. After the edge it checks that the value was actually stored.

// File: rtl/windowed_regfile.sv
module windowed_regfile #(
  parameter int DW   = 32,
  parameter int NWIN = 8,
  parameter int GRP  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NWIN)-1:0]   cwp,
  input  logic                      we,
  input  logic [$clog2(4*GRP)-1:0]  wa_addr,
  input  logic [DW-1:0]             wa_data,
  input  logic [$clog2(4*GRP)-1:0]  ra_addr,
  output logic [DW-1:0]             ra_data,
  input  logic [$clog2(4*GRP)-1:0]  rb_addr,
  output logic [DW-1:0]             rb_data
);
  localparam int LW    = $clog2(4*GRP);
  localparam int CW    = $clog2(NWIN);
  localparam int WREG  = 2*GRP*NWIN;
  localparam int WW    = $clog2(WREG);
  localparam int NPHYS = GRP + WREG;
  localparam int PW    = $clog2(NPHYS);
  localparam int BASE  = WREG - 3*GRP;
  localparam int STEP  = 2*GRP;

  function automatic logic [PW-1:0] phys(input logic [LW-1:0] l, input logic [CW-1:0] w);
    logic [WW-1:0] j;
    if (int'(l) < GRP) return PW'(l);
    j = WW'(BASE + int'(l) - GRP - STEP*int'(w));
    return PW'(GRP) + PW'(j);
  endfunction

  logic [DW-1:0] rf [NPHYS];
  logic [PW-1:0] pw, pa, pb;
  logic          wr;

  assign pw = phys(wa_addr, cwp);
  assign pa = phys(ra_addr, cwp);
  assign pb = phys(rb_addr, cwp);
  assign wr = we && (wa_addr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
    end else if (wr) begin
      rf[pw] <= wa_data;
    end
  end

  assign ra_data = (ra_addr == '0) ? '0 : (wr && pw == pa) ? wa_data : rf[pa];
  assign rb_data = (rb_addr == '0) ? '0 : (wr && pw == pb) ? wa_data : rf[pb];

  AST_ZERO_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == '0); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rf[$past(pw)] == $past(wa_data)); // R9

  AST_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ra_addr == wa_addr) |-> ra_data == wa_data); // R8

  AST_OVERLAP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(wa_addr) >= GRP && int'(wa_addr) < 2*GRP)
      |=> rf[phys(LW'($past(wa_addr) + LW'(2*GRP)), CW'($past(cwp) + 1'b1))] == $past(wa_data)); // R5

  AST_GLOBAL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(wa_addr) < GRP) |=> rf[PW'($past(wa_addr))] == $past(wa_data)); // R2
endmodule

// File: tb/windowed_regfile_test.sv
module windowed_regfile_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  cwp = 0;
  logic        we = 0;
  logic [4:0]  wa_addr = 0, ra_addr = 0, rb_addr = 0;
  logic [31:0] wa_data = 0;
  logic [31:0] ra_data, rb_data;
  int checks = 0, errors = 0;
  bit done = 0;

  windowed_regfile uut (.clk(clk), .rst_n(rst_n), .cwp(cwp), .we(we), .wa_addr(wa_addr),
    .wa_data(wa_data), .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] tv(int w, int k); return 32'hA000_0000 | (w << 8) | k; endfunction
  function automatic logic [31:0] lv(int w, int k); return 32'h5000_0000 | (w << 8) | k; endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int w, int a, logic [31:0] d);
    @(negedge clk); cwp = 3'(w); we = 1; wa_addr = 5'(a); wa_data = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(int w, int a, int b);
    @(negedge clk); cwp = 3'(w); ra_addr = 5'(a); rb_addr = 5'(b); #1;
  endtask

  task automatic t_reset;
    for (int w = 0; w < 8; w++)
      for (int a = 0; a < 32; a++) begin
        rd(w, a, 31 - a);
        check("R1 port A", ra_data, 0);
        check("R1 port B", rb_data, 0);
      end
  endtask

  task automatic t_globals;
    for (int k = 1; k < 8; k++) wr(k, k, 32'h6000_0000 | k);
    for (int w = 0; w < 8; w++)
      for (int k = 1; k < 8; k++) begin
        rd(w, k, k);
        check("R2 global", ra_data, 32'h6000_0000 | k);
      end
  endtask

  task automatic t_zero;
    wr(5, 0, 32'hDEAD_BEEF);
    for (int w = 0; w < 8; w++) begin
      rd(w, 0, 0);
      check("R3 zero A", ra_data, 0);
      check("R3 zero B", rb_data, 0);
    end
    rd(0, 1, 7);
    check("R3 globals intact", ra_data, 32'h6000_0001);
  endtask

  task automatic t_overlap;
    for (int w = 0; w < 8; w++)
      for (int k = 0; k < 8; k++) wr(w, 8 + k, tv(w, k));
    for (int w = 0; w < 8; w++)
      for (int k = 0; k < 8; k++) begin
        rd((w + 1) % 8, 24 + k, 8 + k);
        check(w == 7 ? "R5 wrap param" : "R5 param", ra_data, tv(w, k));
        check("R4 next temp", rb_data, tv((w + 1) % 8, k));
      end
  endtask

  task automatic t_locals;
    for (int w = 0; w < 8; w++)
      for (int k = 0; k < 8; k++) wr(w, 16 + k, lv(w, k));
    for (int w = 0; w < 8; w++)
      for (int k = 0; k < 8; k++) begin
        rd(w, 16 + k, 8 + k);
        check("R6 local", ra_data, lv(w, k));
        check("R6 temp intact", rb_data, tv(w, k));
        rd(w, 24 + k, 16 + k);
        check("R6 param intact", ra_data, tv((w + 7) % 8, k));
        check("R7 port B local", rb_data, lv(w, k));
      end
  endtask

  task automatic t_forward;
    @(negedge clk);
    cwp = 3; we = 1; wa_addr = 17; wa_data = 32'hF00D_0001; ra_addr = 17; rb_addr = 18; #1;
    check("R8 forward A", ra_data, 32'hF00D_0001);
    check("R8 other B", rb_data, lv(3, 2));
    @(negedge clk); we = 0; #1;
    check("R9 stored", ra_data, 32'hF00D_0001);
    @(negedge clk);
    cwp = 6; we = 1; wa_addr = 12; wa_data = 32'hF00D_0002; ra_addr = 5; rb_addr = 12; #1;
    check("R8 forward B", rb_data, 32'hF00D_0002);
    check("R7 port A global", ra_data, 32'h6000_0005);
    @(negedge clk); we = 0;
    rd(7, 28, 12);
    check("R9 held via R5", ra_data, 32'hF00D_0002);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_globals;
    t_zero;
    t_overlap;
    t_locals;
    t_forward;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule